// File: doc/BRIEF.md
# PROM Burn Sequencer

This block writes a complete image into an erasable PROM with a pulse-and-verify algorithm. After a start command it fetches each source byte over a request/acknowledge port. It drives the byte's address and data onto the device and issues timed programming pulses. It raises and lowers the two programming voltages through two enable outputs. It reads bytes back through a verify strobe and reports the result.

The algorithm has three passes. The burn pass gives every address exactly one pulse and reads nothing back. The retry pass reads every byte back at the raised voltages. On a mismatch it pulses again, one pulse at a time with a read after each, up to a retry limit. The final pass first lowers both voltages, then re-reads the whole array at normal voltage. All intervals (pulse, setup, hold) are given in nanoseconds together with the clock frequency, and are turned into whole clock cycles, always rounded up.

Top module: `prog_seq`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. Accepting it raises `busy` and clears `done`, `pass`, `fail` and `fail_addr` on the next cycle. A `start` seen while `busy` is high has no effect.
- R2: `vcc_hi_en` rises on the cycle after start is accepted. `vpp_en` follows SETUP cycles later, and after another SETUP cycles the first fetch begins. When the retry pass ends, `vpp_en` falls first and `vcc_hi_en` falls SETUP cycles later; SETUP more cycles pass before anything else happens. `vpp_en` is never high while `vcc_hi_en` is low.
- R3: Before each pulse, address and data are driven (`drive_en` high, `prog_pulse` low) for SETUP cycles. `drive_en` stays high for HOLD cycles after the pulse ends. A pulse occurs only while both voltage enables are high.
- R4: Each interval lasts ceil(ns × CLK_KHZ / 1e6) cycles, with a minimum of 1. A pulse is exactly PULSE cycles.
- R5: In the burn pass, addresses are visited in ascending order from 0. Each gets exactly one pulse, and `verify_stb` stays low.
- R6: In the retry pass, each address gets one `verify_stb` cycle, and `dev_rdata` is compared with the source byte in that cycle. On a mismatch the block runs another setup/pulse/hold and verifies again. A byte that matches moves the block to the next address.
- R7: If a byte still mismatches after MAX_RETRY extra pulses, `fail_addr` takes that address. Both voltages are lowered in the R2 order, and the block ends with `done` and `fail` high.
- R8: The final pass verifies every address in ascending order with both enables low. The first mismatch ends the run with `done`, `fail` and `fail_addr` set. If every byte matches, the run ends with `done` and `pass`.
- R9: In each source fetch, `src_req` stays high with `src_addr` equal to the current address until a cycle with `src_ack` high. The byte on `src_data` in that cycle is the data driven on `dev_wdata`.
- R10: `done`, `pass`, `fail` and `fail_addr` keep their final values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a programming run |
| src_req | output | 1 | Source byte request |
| src_addr | output | ADDR_W | Address of the requested source byte |
| src_ack | input | 1 | Source byte valid this cycle |
| src_data | input | DATA_W | Source byte |
| dev_addr | output | ADDR_W | Device address |
| dev_wdata | output | DATA_W | Byte driven to the device |
| drive_en | output | 1 | Write data is being driven |
| prog_pulse | output | 1 | Programming pulse |
| verify_stb | output | 1 | Read-back cycle; `dev_rdata` compared this cycle |
| dev_rdata | input | DATA_W | Byte read from the device |
| vcc_hi_en | output | 1 | Raise supply to programming level |
| vpp_en | output | 1 | Raise programming voltage |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with all bytes matching |
| fail | output | 1 | Run finished with a failing byte |
| fail_addr | output | ADDR_W | Address of the failing byte |

## Verification
The bench builds the block with a 3-bit address, so one full three-pass run takes a few hundred cycles. It uses CLK_KHZ=250000 with 20/8/5 ns intervals, giving 5/2/2 cycles; the 5 ns hold rounds up from 1.25 cycles, which exercises the rounding rule. MAX_RETRY stays at its default of 10. Device cells that need exactly eleven pulses or twelve pulses therefore sit on either side of the retry limit. A cell that reads wrong only at normal voltage reaches the final-pass failure.

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int CLK_KHZ   = 50000,
  parameter int PULSE_NS  = 100000,
  parameter int SETUP_NS  = 2000,
  parameter int HOLD_NS   = 2000,
  parameter int MAX_RETRY = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              src_req,
  output logic [ADDR_W-1:0] src_addr,
  input  logic              src_ack,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              drive_en,
  output logic              prog_pulse,
  output logic              verify_stb,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic              vcc_hi_en,
  output logic              vpp_en,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  function automatic int to_cyc(longint ns);
    longint t;
    t = (ns * longint'(CLK_KHZ) + 64'd999999) / 64'd1000000;
    return (t < 1) ? 1 : int'(t);
  endfunction

  localparam int PULSE_CYC = to_cyc(PULSE_NS);
  localparam int SETUP_CYC = to_cyc(SETUP_NS);
  localparam int HOLD_CYC  = to_cyc(HOLD_NS);
  localparam int MAX_A     = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int MAX_CYC   = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam int TRY_W     = $clog2(MAX_RETRY + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_VCC_UP, S_VPP_UP, S_FETCH, S_SETUP,
    S_PULSE, S_HOLD, S_VERIFY, S_VPP_DN, S_VCC_DN
  } state_t;

  typedef enum logic [1:0] {P_BURN, P_RETRY, P_FINAL} pass_t;

  state_t            state;
  pass_t             phase;
  logic [CNT_W-1:0]  cnt, lim;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdat;
  logic [TRY_W-1:0]  tries;
  logic              failing, vcc_r, vpp_r;
  logic              done_r, pass_r, fail_r;
  logic [ADDR_W-1:0] faddr_r;
  logic              span_end, last, match;

  always_comb begin
    case (state)
      S_PULSE: lim = CNT_W'(PULSE_CYC);
      S_HOLD:  lim = CNT_W'(HOLD_CYC);
      default: lim = CNT_W'(SETUP_CYC);
    endcase
  end

  assign span_end = (cnt == lim - 1'b1);
  assign last     = &addr;
  assign match    = (dev_rdata == wdat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phase   <= P_BURN;
      cnt     <= '0;
      addr    <= '0;
      wdat    <= '0;
      tries   <= '0;
      failing <= 1'b0;
      vcc_r   <= 1'b0;
      vpp_r   <= 1'b0;
      done_r  <= 1'b0;
      pass_r  <= 1'b0;
      fail_r  <= 1'b0;
      faddr_r <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_VCC_UP;
          cnt     <= '0;
          vcc_r   <= 1'b1;
          phase   <= P_BURN;
          addr    <= '0;
          tries   <= '0;
          failing <= 1'b0;
          done_r  <= 1'b0;
          pass_r  <= 1'b0;
          fail_r  <= 1'b0;
          faddr_r <= '0;
        end
        S_VCC_UP: if (span_end) begin
          state <= S_VPP_UP;
          cnt   <= '0;
          vpp_r <= 1'b1;
        end
        S_VPP_UP: if (span_end) begin
          state <= S_FETCH;
          cnt   <= '0;
        end
        S_FETCH: if (src_ack) begin
          wdat  <= src_data;
          cnt   <= '0;
          state <= (phase == P_BURN) ? S_SETUP : S_VERIFY;
        end
        S_SETUP: if (span_end) begin
          state <= S_PULSE;
          cnt   <= '0;
        end
        S_PULSE: if (span_end) begin
          state <= S_HOLD;
          cnt   <= '0;
        end
        S_HOLD: if (span_end) begin
          cnt <= '0;
          if (phase != P_BURN) state <= S_VERIFY;
          else if (!last) begin
            addr  <= addr + 1'b1;
            state <= S_FETCH;
          end else begin
            phase <= P_RETRY;
            addr  <= '0;
            state <= S_FETCH;
          end
        end
        S_VERIFY: begin
          cnt <= '0;
          if (match) begin
            tries <= '0;
            if (!last) begin
              addr  <= addr + 1'b1;
              state <= S_FETCH;
            end else if (phase == P_RETRY) begin
              state <= S_VPP_DN;
              vpp_r <= 1'b0;
            end else begin
              state  <= S_IDLE;
              done_r <= 1'b1;
              pass_r <= 1'b1;
            end
          end else if (phase == P_RETRY && tries != TRY_W'(MAX_RETRY)) begin
            tries <= tries + 1'b1;
            state <= S_SETUP;
          end else begin
            faddr_r <= addr;
            if (phase == P_RETRY) begin
              failing <= 1'b1;
              state   <= S_VPP_DN;
              vpp_r   <= 1'b0;
            end else begin
              state  <= S_IDLE;
              done_r <= 1'b1;
              fail_r <= 1'b1;
            end
          end
        end
        S_VPP_DN: if (span_end) begin
          state <= S_VCC_DN;
          cnt   <= '0;
          vcc_r <= 1'b0;
        end
        S_VCC_DN: if (span_end) begin
          cnt <= '0;
          if (failing) begin
            state  <= S_IDLE;
            done_r <= 1'b1;
            fail_r <= 1'b1;
          end else begin
            phase <= P_FINAL;
            addr  <= '0;
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign src_req    = (state == S_FETCH);
  assign src_addr   = addr;
  assign dev_addr   = addr;
  assign dev_wdata  = wdat;
  assign drive_en   = (state == S_SETUP) || (state == S_PULSE) || (state == S_HOLD);
  assign prog_pulse = (state == S_PULSE);
  assign verify_stb = (state == S_VERIFY);
  assign vcc_hi_en  = vcc_r;
  assign vpp_en     = vpp_r;
  assign busy       = (state != S_IDLE);
  assign done       = done_r;
  assign pass       = pass_r;
  assign fail       = fail_r;
  assign fail_addr  = faddr_r;

endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int ADDR_W    = 13,
  parameter int PULSE_CYC = 1,
  parameter int SETUP_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_req,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              drive_en,
  input logic              prog_pulse,
  input logic              verify_stb,
  input logic              vcc_hi_en,
  input logic              vpp_en,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail
);

  logic [31:0] pw_cnt, su_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_cnt <= '0;
      su_cnt <= '0;
    end else begin
      pw_cnt <= prog_pulse ? pw_cnt + 1 : '0;
      su_cnt <= (drive_en && !prog_pulse) ? su_cnt + 1 : '0;
    end
  end

  assert_vpp_needs_vcc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_en |-> vcc_hi_en);

  assert_pulse_conditions_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> (vcc_hi_en && vpp_en && drive_en));

  assert_setup_before_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_pulse) |-> (su_cnt >= 32'(SETUP_CYC)));

  assert_hold_after_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_pulse) |-> drive_en);

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && $past(drive_en)) |-> $stable(dev_addr));

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_pulse) |-> (pw_cnt == 32'(PULSE_CYC)));

  assert_verify_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    verify_stb |-> !drive_en);

  assert_one_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_pulse, verify_stb, src_req}));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && (pass != fail)));

endmodule

bind prog_seq prog_seq_chk #(
  .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .SETUP_CYC(SETUP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .dev_addr(dev_addr),
  .drive_en(drive_en), .prog_pulse(prog_pulse), .verify_stb(verify_stb),
  .vcc_hi_en(vcc_hi_en), .vpp_en(vpp_en), .busy(busy), .done(done),
  .pass(pass), .fail(fail)
);

// File: tb/prog_seq_test.sv
`timescale 1ns/1ps
module prog_seq_test;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int PC = 5;   // 20 ns at 250 MHz
  localparam int SC = 2;   // 8 ns
  localparam int HC = 2;   // 5 ns rounded up
  localparam int MAXR = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic src_req, src_ack, drive_en, prog_pulse, verify_stb, vcc_hi_en, vpp_en;
  logic busy, done, pass, fail;
  logic [AW-1:0] src_addr, dev_addr, fail_addr;
  logic [DW-1:0] src_data, dev_wdata, dev_rdata;

  always #2 clk = ~clk;

  prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_KHZ(250000), .PULSE_NS(20),
             .SETUP_NS(8), .HOLD_NS(5), .MAX_RETRY(MAXR)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_req(src_req), .src_addr(src_addr),
    .src_ack(src_ack), .src_data(src_data), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .drive_en(drive_en), .prog_pulse(prog_pulse), .verify_stb(verify_stb),
    .dev_rdata(dev_rdata), .vcc_hi_en(vcc_hi_en), .vpp_en(vpp_en), .busy(busy),
    .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr));

  int checks = 0, fails = 0, seed = 0, runs_done = 0;
  bit finished = 0, mon_on = 0, stall = 0, ok = 1;
  int need [N];
  bit leaky [N];
  int dcnt [N];
  logic [DW-1:0] mem [N];
  logic [7:0] lfsr = 8'h5A;

  function automatic logic [DW-1:0] img_of(int a);
    return DW'(a * 29 + 7 + seed * 3);
  endfunction

  // source port with optional stalls
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ok = stall ? lfsr[0] : 1'b1;
  end
  assign src_ack  = src_req & ok;
  assign src_data = img_of(int'(src_addr));

  // device model: cell takes the byte once it has seen enough pulses
  logic prev_pulse = 0;
  always @(posedge clk) begin
    if (prog_pulse && !prev_pulse) begin
      dcnt[dev_addr] = dcnt[dev_addr] + 1;
      if (dcnt[dev_addr] >= need[dev_addr]) mem[dev_addr] = dev_wdata;
    end
    prev_pulse = prog_pulse;
  end
  assign dev_rdata = mem[dev_addr] ^ ((leaky[dev_addr] && !vcc_hi_en) ? 8'hFF : 8'h00);

  // behavioural reference model
  logic e_busy = 0, e_done = 0, e_pass = 0, e_fail = 0, e_req = 0, e_drive = 0;
  logic e_pulse = 0, e_ver = 0, e_vcc = 0, e_vpp = 0;
  int e_faddr = 0, e_saddr = 0, e_daddr = 0, e_wdata = 0;
  int pm [N];

  task automatic span(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic fetch(int a);
    bit got;
    e_req = 1; e_saddr = a;
    do begin
      @(negedge clk); got = ok;
      @(posedge clk); #1;
    end while (!got);
    e_req = 0;
  endtask

  task automatic burst(int a);
    e_drive = 1; e_daddr = a; e_wdata = int'(img_of(a));
    span(SC);
    e_pulse = 1; pm[a]++;
    span(PC);
    e_pulse = 0;
    span(HC);
    e_drive = 0;
  endtask

  task automatic verify(int a);
    e_ver = 1; e_daddr = a;
    span(1);
    e_ver = 0;
  endtask

  task automatic finish_run(bit good);
    e_busy = 0; e_done = 1; e_pass = good; e_fail = !good;
    runs_done++;
  endtask

  task automatic model_run();
    bit bad = 0;
    for (int a = 0; a < N; a++) pm[a] = 0;
    e_busy = 1; e_done = 0; e_pass = 0; e_fail = 0; e_faddr = 0; e_vcc = 1;
    span(SC);
    e_vpp = 1;
    span(SC);
    for (int a = 0; a < N; a++) begin fetch(a); burst(a); end
    for (int a = 0; a < N && !bad; a++) begin
      int tries = 0;
      fetch(a);
      forever begin
        verify(a);
        if (pm[a] >= need[a]) break;
        if (tries == MAXR) begin bad = 1; e_faddr = a; break; end
        tries++;
        burst(a);
      end
    end
    e_vpp = 0;
    span(SC);
    e_vcc = 0;
    span(SC);
    if (bad) begin finish_run(0); return; end
    for (int a = 0; a < N; a++) begin
      fetch(a);
      verify(a);
      if (leaky[a]) begin e_faddr = a; finish_run(0); return; end
    end
    finish_run(1);
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      if (start) begin #1; model_run(); end
    end
  end

  task automatic cmp(string tag, string nm, int act, int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, nm, act, exp, $time);
      bad = 1;
    end
  endtask

  always @(negedge clk) if (mon_on && !finished) begin
    bit bad = 0;
    cmp("R1", "busy", busy, e_busy, bad);
    cmp("R10", "done", done, e_done, bad);
    cmp("R8", "pass", pass, e_pass, bad);
    cmp("R7", "fail", fail, e_fail, bad);
    cmp("R7", "fail_addr", fail_addr, e_faddr, bad);
    cmp("R2", "vcc_hi_en", vcc_hi_en, e_vcc, bad);
    cmp("R2", "vpp_en", vpp_en, e_vpp, bad);
    cmp("R3", "drive_en", drive_en, e_drive, bad);
    cmp("R4", "prog_pulse", prog_pulse, e_pulse, bad);
    cmp("R6", "verify_stb", verify_stb, e_ver, bad);
    cmp("R9", "src_req", src_req, e_req, bad);
    if (e_req) cmp("R9", "src_addr", src_addr, e_saddr, bad);
    if (e_drive || e_ver) cmp("R5", "dev_addr", dev_addr, e_daddr, bad);
    if (e_drive) cmp("R9", "dev_wdata", dev_wdata, e_wdata, bad);
    checks++;
    if (bad) fails++;
  end

  task automatic check(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, nm, act, exp);
    end
  endtask

  task automatic setup_run(int s);
    @(negedge clk);
    seed = s;
    for (int a = 0; a < N; a++) begin need[a] = 1; leaky[a] = 0; dcnt[a] = 0; mem[a] = '1; end
  endtask

  task automatic go_and_wait();
    int tgt = runs_done + 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    wait (runs_done == tgt);
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset busy", busy, 0);
    check("R2", "reset vcc_hi_en", vcc_hi_en, 0);
    check("R2", "reset vpp_en", vpp_en, 0);
    check("R10", "reset done", done, 0);
    rst_n = 1;
    mon_on = 1;

    // clean image, one pulse per byte
    setup_run(1);
    go_and_wait();
    check("R8", "run1 pass", pass, 1);
    for (int a = 0; a < N; a++) check("R5", "run1 pulses", dcnt[a], 1);

    // slow cells, stalls, start ignored while busy, eleven-pulse boundary
    setup_run(2);
    need[1] = 4; need[3] = 11; need[6] = 2; stall = 1;
    fork
      go_and_wait();
      begin repeat (40) @(negedge clk); start = 1; @(negedge clk); start = 0; end
    join
    check("R6", "run2 pass", pass, 1);
    check("R6", "run2 pulses addr3", dcnt[3], 11);
    check("R6", "run2 pulses addr1", dcnt[1], 4);
    check("R1", "run2 single run", runs_done, 2);

    // cell beyond the retry limit
    setup_run(3);
    need[5] = 12; stall = 0;
    go_and_wait();
    check("R7", "run3 fail", fail, 1);
    check("R7", "run3 fail_addr", fail_addr, 5);
    check("R7", "run3 pulses addr5", dcnt[5], 11);
    check("R7", "run3 later addr untouched", dcnt[6], 1);
    check("R2", "run3 vcc low", vcc_hi_en, 0);

    // cell that reads wrong only at normal voltage
    setup_run(4);
    leaky[6] = 1; need[2] = 3;
    go_and_wait();
    check("R8", "run4 fail", fail, 1);
    check("R8", "run4 fail_addr", fail_addr, 6);
    repeat (20) @(negedge clk);
    check("R10", "run4 status held", fail_addr, 6);

    // next start clears failure status
    setup_run(5);
    go_and_wait();
    check("R10", "run5 pass after fail", pass, 1);
    check("R10", "run5 fail_addr cleared", fail_addr, 0);

    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end
endmodule